// File: doc/BRIEF.md
# VMEbus Read-Modify-Write Sequencer

This block sits between the host bus front end and the VMEbus master engine. It turns host accesses into per-beat master commands, and it keeps the VMEbus held across a locked read-modify-write sequence. A locked read that targets the VMEbus opens an indivisible cycle, and the bus hold is raised with it. The next VMEbus access the host makes closes that cycle, whatever its direction or lock tag. The hold drops once the closing beat completes.

Each access is checked against the 32-bit word grid. An access that runs past a word boundary is cut into two beats. When a split or misaligned access opens or closes a locked cycle, the cycle cannot be atomic, so the block raises a one-cycle violation flag. The master engine finishes each command by pulsing a done input. The host may abort a held cycle while the block waits for the closing access.

Top module: `vme_rmw_seq`

## Requirements
- R1: After reset, bus_hold_o, cmd_valid_o and atom_viol_o are low and host_ready_o is high.
- R2: An accepted unlocked VMEbus access, or a locked write, made while no cycle is held is issued as a command with the same address, byte count and direction. bus_hold_o stays low, and host_done_o pulses in the cycle in which cmd_done_i completes the last beat.
- R3: An accepted locked read (host_lock_i=1, host_write_i=0) raises bus_hold_o in the cycle after acceptance. The hold stays high through the read beat and while the block waits for the closing access.
- R4: While a cycle is held, the next accepted VMEbus access of any direction or lock tag is issued as the closing command. bus_hold_o falls in the cycle after that command completes, and host_ready_o returns high.
- R5: A request with host_vme_i=0 is ignored. No command is issued, and the state, including bus_hold_o, is unchanged.
- R6: An access whose low address bits plus its byte count exceed 4 is issued as two beats. The first beat uses the original address with 4 minus addr[1:0] bytes. The second uses the next word-aligned address with the remaining bytes. Every command stays inside one 32-bit word.
- R7: When a locked read is split, its second beat acts as the closing access. bus_hold_o falls after that beat, and atom_viol_o pulses in the cycle after acceptance.
- R8: A locked read whose address is not a multiple of its byte count raises atom_viol_o in the cycle after acceptance. This holds even when the access is not split. An aligned locked read raises no flag.
- R9: When the closing access is split or misaligned, atom_viol_o pulses in the cycle after acceptance. Its first beat ends the hold, so bus_hold_o is low while the second beat runs.
- R10: host_abort_i while the block waits for the closing access drops bus_hold_o in the next cycle. It issues no command and wins over a request in the same cycle. At any other time host_abort_i has no effect.
- R11: host_size_i encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes.
- R12: host_ready_o is low while a command is outstanding. A request made then is ignored and produces no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access request |
| host_vme_i | input | 1 | Access maps to the VMEbus |
| host_lock_i | input | 1 | Access carries the lock tag |
| host_write_i | input | 1 | 1 = write, 0 = read |
| host_size_i | input | 2 | Access size code |
| host_addr_i | input | AW | Byte address |
| host_abort_i | input | 1 | Abandon a held cycle |
| host_ready_o | output | 1 | Request is accepted this cycle |
| host_done_o | output | 1 | Last beat of an access completes |
| cmd_valid_o | output | 1 | Command to master engine pending |
| cmd_addr_o | output | AW | Command address |
| cmd_bytes_o | output | $clog2(WORD_BYTES)+1 | Command byte count |
| cmd_write_o | output | 1 | Command direction |
| cmd_done_i | input | 1 | Engine completes the current command |
| bus_hold_o | output | 1 | Keep VMEbus ownership |
| atom_viol_o | output | 1 | Atomicity violation pulse |

## Verification
The sequencer is driven with aligned plain accesses, aligned locked read and close pairs, and closes made with reads and locked accesses. These show that a cycle ends on the next VMEbus access and not on a write. Boundary-crossing 16-bit and 32-bit accesses check the beat split. When such accesses open or close a locked cycle, they show whether the hold ends on the right beat and whether the violation flag rises. Misaligned accesses that stay inside a word separate the misalignment flag from the split. Non-VMEbus requests, requests made while busy, and aborts placed against a same-cycle request or made outside a hold each check a path that must leave the state alone.

// File: rtl/rmw_seq_pkg.sv
`timescale 1ns/1ps
package rmw_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RMW_READ,
    ST_RMW_HOLD,
    ST_RMW_WRITE,
    ST_PASS
  } rmw_state_e;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] size);
    case (size)
      2'd0:    size_to_bytes = 3'd1;
      2'd1:    size_to_bytes = 3'd2;
      default: size_to_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/rmw_split.sv
`timescale 1ns/1ps
module rmw_split #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0]                 addr_i,
  input  logic [1:0]                    size_i,
  output logic [AW-1:0]                 b0_addr_o,
  output logic [$clog2(WORD_BYTES):0]   b0_bytes_o,
  output logic [AW-1:0]                 b1_addr_o,
  output logic [$clog2(WORD_BYTES):0]   b1_bytes_o,
  output logic                          split_o,
  output logic                          misalign_o
);
  import rmw_seq_pkg::*;

  localparam int OFF_W = $clog2(WORD_BYTES);
  localparam int BW    = OFF_W + 1;
  localparam int HW    = AW - OFF_W;
  localparam logic [HW-1:0] ONE_WORD = HW'(1);

  logic [BW-1:0] len, off, room, mask;

  always_comb begin
    len  = BW'(size_to_bytes(size_i));
    off  = {1'b0, addr_i[OFF_W-1:0]};
    room = BW'(WORD_BYTES) - off;
    mask = len - BW'(1);
  end

  assign split_o    = len > room;
  assign misalign_o = |(addr_i[OFF_W-1:0] & mask[OFF_W-1:0]);
  assign b0_addr_o  = addr_i;
  assign b0_bytes_o = split_o ? room : len;
  assign b1_addr_o  = {addr_i[AW-1:OFF_W] + ONE_WORD, {OFF_W{1'b0}}};
  assign b1_bytes_o = split_o ? (len - room) : '0;

endmodule

// File: rtl/rmw_issue.sv
`timescale 1ns/1ps
module rmw_issue #(
  parameter int AW = 32,
  parameter int BW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          two_i,
  input  logic          write_i,
  input  logic [AW-1:0] b0_addr_i,
  input  logic [BW-1:0] b0_bytes_i,
  input  logic [AW-1:0] b1_addr_i,
  input  logic [BW-1:0] b1_bytes_i,
  input  logic          done_i,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [BW-1:0] cmd_bytes_o,
  output logic          cmd_write_o,
  output logic          first_done_o,
  output logic          last_done_o
);

  logic          cur_vld_q, pend_vld_q, wr_q;
  logic [AW-1:0] cur_addr_q, pend_addr_q;
  logic [BW-1:0] cur_bytes_q, pend_bytes_q;

  assign first_done_o = done_i & cur_vld_q & pend_vld_q;
  assign last_done_o  = done_i & cur_vld_q & ~pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_vld_q    <= 1'b0;
      pend_vld_q   <= 1'b0;
      wr_q         <= 1'b0;
      cur_addr_q   <= '0;
      cur_bytes_q  <= '0;
      pend_addr_q  <= '0;
      pend_bytes_q <= '0;
    end else if (load_i) begin
      cur_vld_q    <= 1'b1;
      pend_vld_q   <= two_i;
      wr_q         <= write_i;
      cur_addr_q   <= b0_addr_i;
      cur_bytes_q  <= b0_bytes_i;
      pend_addr_q  <= b1_addr_i;
      pend_bytes_q <= b1_bytes_i;
    end else if (first_done_o) begin
      pend_vld_q  <= 1'b0;
      cur_addr_q  <= pend_addr_q;
      cur_bytes_q <= pend_bytes_q;
    end else if (last_done_o) begin
      cur_vld_q <= 1'b0;
    end
  end

  assign cmd_valid_o = cur_vld_q;
  assign cmd_addr_o  = cur_addr_q;
  assign cmd_bytes_o = cur_bytes_q;
  assign cmd_write_o = wr_q;

endmodule

// File: rtl/rmw_fsm.sv
`timescale 1ns/1ps
module rmw_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic lock_i,
  input  logic write_i,
  input  logic split_i,
  input  logic misalign_i,
  input  logic abort_i,
  input  logic first_done_i,
  input  logic last_done_i,
  output logic ready_o,
  output logic acc_o,
  output logic hold_o,
  output logic viol_o
);
  import rmw_seq_pkg::*;

  rmw_state_e st_q, st_d;
  logic       viol_q, opens, closes;

  assign ready_o = (st_q == ST_IDLE) | ((st_q == ST_RMW_HOLD) & ~abort_i);
  assign acc_o   = req_i & ready_o;
  assign opens   = (st_q == ST_IDLE) & lock_i & ~write_i;
  assign closes  = (st_q == ST_RMW_HOLD);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (acc_o) st_d = opens ? ST_RMW_READ : ST_PASS;
      ST_RMW_READ:  if (first_done_i) st_d = ST_RMW_WRITE;  // second half closes
                    else if (last_done_i) st_d = ST_RMW_HOLD;
      ST_RMW_HOLD:  if (abort_i) st_d = ST_IDLE;
                    else if (acc_o) st_d = ST_RMW_WRITE;
      ST_RMW_WRITE: if (first_done_i) st_d = ST_PASS;       // tail runs unheld
                    else if (last_done_i) st_d = ST_IDLE;
      ST_PASS:      if (last_done_i) st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      viol_q <= acc_o & (opens | closes) & (split_i | misalign_i);
    end
  end

  assign hold_o = (st_q == ST_RMW_READ) | (st_q == ST_RMW_HOLD) | (st_q == ST_RMW_WRITE);
  assign viol_o = viol_q;

endmodule

// File: rtl/vme_rmw_seq.sv
`timescale 1ns/1ps
module vme_rmw_seq #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int BW        = $clog2(WORD_BYTES) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  input  logic          host_vme_i,
  input  logic          host_lock_i,
  input  logic          host_write_i,
  input  logic [1:0]    host_size_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_abort_i,
  output logic          host_ready_o,
  output logic          host_done_o,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [BW-1:0] cmd_bytes_o,
  output logic          cmd_write_o,
  input  logic          cmd_done_i,
  output logic          bus_hold_o,
  output logic          atom_viol_o
);

  logic [AW-1:0] b0_addr, b1_addr;
  logic [BW-1:0] b0_bytes, b1_bytes;
  logic          split, misalign, acc, first_done, last_done;

  rmw_split #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_split (
    .addr_i     (host_addr_i),
    .size_i     (host_size_i),
    .b0_addr_o  (b0_addr),
    .b0_bytes_o (b0_bytes),
    .b1_addr_o  (b1_addr),
    .b1_bytes_o (b1_bytes),
    .split_o    (split),
    .misalign_o (misalign)
  );

  rmw_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (host_req_i & host_vme_i),
    .lock_i       (host_lock_i),
    .write_i      (host_write_i),
    .split_i      (split),
    .misalign_i   (misalign),
    .abort_i      (host_abort_i),
    .first_done_i (first_done),
    .last_done_i  (last_done),
    .ready_o      (host_ready_o),
    .acc_o        (acc),
    .hold_o       (bus_hold_o),
    .viol_o       (atom_viol_o)
  );

  rmw_issue #(.AW(AW), .BW(BW)) u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (acc),
    .two_i        (split),
    .write_i      (host_write_i),
    .b0_addr_i    (b0_addr),
    .b0_bytes_i   (b0_bytes),
    .b1_addr_i    (b1_addr),
    .b1_bytes_i   (b1_bytes),
    .done_i       (cmd_done_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_bytes_o  (cmd_bytes_o),
    .cmd_write_o  (cmd_write_o),
    .first_done_o (first_done),
    .last_done_o  (last_done)
  );

  assign host_done_o = last_done;

endmodule

// File: rtl/vme_rmw_seq_chk.sv
`timescale 1ns/1ps
module vme_rmw_seq_chk #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        host_req_i,
  input logic                        host_vme_i,
  input logic                        host_lock_i,
  input logic                        host_write_i,
  input logic                        host_abort_i,
  input logic                        host_ready_o,
  input logic                        cmd_valid_o,
  input logic [AW-1:0]               cmd_addr_o,
  input logic [$clog2(WORD_BYTES):0] cmd_bytes_o,
  input logic                        bus_hold_o,
  input logic                        atom_viol_o
);
  localparam int OFF_W = $clog2(WORD_BYTES);
  localparam int EW    = OFF_W + 2;

  logic          acc;
  logic [EW-1:0] beat_end;

  assign acc      = host_req_i & host_vme_i & host_ready_o;
  assign beat_end = EW'(cmd_addr_o[OFF_W-1:0]) + EW'(cmd_bytes_o);

  assert_open_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && host_lock_i && !host_write_i && !bus_hold_o |=> bus_hold_o && cmd_valid_o);

  assert_plain_nohold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !bus_hold_o && !(host_lock_i && !host_write_i) |=> !bus_hold_o && cmd_valid_o);

  assert_beat_in_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (beat_end <= EW'(WORD_BYTES)) && (cmd_bytes_o != '0));

  assert_abort_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_hold_o && !cmd_valid_o && host_abort_i |=> !bus_hold_o && !cmd_valid_o);

  assert_ready_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |-> !cmd_valid_o);

  assert_viol_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atom_viol_o |-> $past(acc));

endmodule

bind vme_rmw_seq vme_rmw_seq_chk #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_req_i   (host_req_i),
  .host_vme_i   (host_vme_i),
  .host_lock_i  (host_lock_i),
  .host_write_i (host_write_i),
  .host_abort_i (host_abort_i),
  .host_ready_o (host_ready_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_bytes_o  (cmd_bytes_o),
  .bus_hold_o   (bus_hold_o),
  .atom_viol_o  (atom_viol_o)
);

// File: tb/tb_vme_rmw_seq.sv
`timescale 1ns/1ps
module tb_vme_rmw_seq;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_req_i = 1'b0, host_vme_i = 1'b0, host_lock_i = 1'b0;
  logic          host_write_i = 1'b0, host_abort_i = 1'b0, cmd_done_i = 1'b0;
  logic [1:0]    host_size_i = 2'd0;
  logic [AW-1:0] host_addr_i = '0;
  logic          host_ready_o, host_done_o, cmd_valid_o, cmd_write_o;
  logic          bus_hold_o, atom_viol_o;
  logic [AW-1:0] cmd_addr_o;
  logic [2:0]    cmd_bytes_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  vme_rmw_seq #(.AW(AW), .WORD_BYTES(4)) dut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Present one request for one clock edge; returns at the following negedge.
  task automatic send(input logic [AW-1:0] a, input logic [1:0] sz, input logic wr,
                      input logic lk, input logic vme, input logic ab);
    host_req_i = 1'b1; host_addr_i = a; host_size_i = sz; host_write_i = wr;
    host_lock_i = lk; host_vme_i = vme; host_abort_i = ab;
    @(posedge clk_i); @(negedge clk_i);
    host_req_i = 1'b0; host_vme_i = 1'b0; host_lock_i = 1'b0; host_abort_i = 1'b0;
  endtask

  // Check the pending command, then complete it.
  task automatic beat(input string req, input logic [AW-1:0] a, input int nb,
                      input logic wr, input logic last);
    chk(req, "cmd_valid", cmd_valid_o, 1);
    chk(req, "cmd_addr", cmd_addr_o, a);
    chk(req, "cmd_bytes", cmd_bytes_o, nb);
    chk(req, "cmd_write", cmd_write_o, wr);
    cmd_done_i = 1'b1;
    #1;
    chk(req, "host_done", host_done_o, last);
    @(posedge clk_i); @(negedge clk_i);
    cmd_done_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1", "ready", host_ready_o, 1);
    chk("R1", "hold", bus_hold_o, 0);
    chk("R1", "cmd_valid", cmd_valid_o, 0);
    chk("R1", "viol", atom_viol_o, 0);
  endtask

  task automatic t_plain();
    send(32'h100, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R2", "hold", bus_hold_o, 0);
    beat("R2", 32'h100, 4, 1'b1, 1'b1);
    chk("R2", "hold after", bus_hold_o, 0);
    chk("R2", "ready after", host_ready_o, 1);
    send(32'h140, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);  // locked write does not open
    chk("R2", "locked write hold", bus_hold_o, 0);
    beat("R2", 32'h140, 4, 1'b1, 1'b1);
    chk("R2", "locked write hold after", bus_hold_o, 0);
  endtask

  task automatic t_rmw_basic();
    send(32'h200, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3", "hold on open", bus_hold_o, 1);
    chk("R8", "aligned no viol", atom_viol_o, 0);
    beat("R3", 32'h200, 4, 1'b0, 1'b1);
    chk("R3", "hold waiting", bus_hold_o, 1);
    chk("R3", "no cmd waiting", cmd_valid_o, 0);
    idle(3);
    chk("R3", "hold persists", bus_hold_o, 1);
    send(32'h200, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4", "hold during close", bus_hold_o, 1);
    beat("R4", 32'h200, 4, 1'b1, 1'b1);
    chk("R4", "hold released", bus_hold_o, 0);
    chk("R4", "ready", host_ready_o, 1);
  endtask

  task automatic t_close_any();
    send(32'h300, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    beat("R3", 32'h300, 2, 1'b0, 1'b1);
    chk("R3", "hold 16b open", bus_hold_o, 1);
    send(32'h9000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);  // locked read closes, not reopens
    beat("R4", 32'h9000, 1, 1'b0, 1'b1);
    chk("R4", "read closes", bus_hold_o, 0);
    chk("R4", "no new cmd", cmd_valid_o, 0);
  endtask

  task automatic t_ignore();
    send(32'h400, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5", "idle non-vme cmd", cmd_valid_o, 0);
    chk("R5", "idle non-vme hold", bus_hold_o, 0);
    send(32'h400, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    beat("R5", 32'h400, 4, 1'b0, 1'b1);
    send(32'h404, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5", "held non-vme cmd", cmd_valid_o, 0);
    chk("R5", "held non-vme hold", bus_hold_o, 1);
    send(32'h408, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    beat("R5", 32'h408, 4, 1'b1, 1'b1);
    chk("R5", "closed by vme", bus_hold_o, 0);
  endtask

  task automatic t_split_plain();
    send(32'h1002, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6", "no viol unlocked", atom_viol_o, 0);
    beat("R6", 32'h1002, 2, 1'b0, 1'b0);
    beat("R6", 32'h1004, 2, 1'b0, 1'b1);
    chk("R6", "done", cmd_valid_o, 0);
    send(32'h2003, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    beat("R6", 32'h2003, 1, 1'b1, 1'b0);
    beat("R6", 32'h2004, 1, 1'b1, 1'b1);
    chk("R6", "hold", bus_hold_o, 0);
  endtask

  task automatic t_split_open();
    send(32'h3001, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7", "viol", atom_viol_o, 1);
    chk("R7", "hold", bus_hold_o, 1);
    beat("R7", 32'h3001, 3, 1'b0, 1'b0);
    chk("R7", "viol pulse ends", atom_viol_o, 0);
    chk("R7", "hold mid", bus_hold_o, 1);
    beat("R7", 32'h3004, 1, 1'b0, 1'b1);
    chk("R7", "closed early", bus_hold_o, 0);
    chk("R7", "ready", host_ready_o, 1);
  endtask

  task automatic t_misalign();
    send(32'h4001, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R8", "viol", atom_viol_o, 1);
    beat("R8", 32'h4001, 2, 1'b0, 1'b1);
    chk("R8", "hold", bus_hold_o, 1);
    send(32'h4000, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8", "aligned close no viol", atom_viol_o, 0);
    beat("R8", 32'h4000, 2, 1'b1, 1'b1);
    chk("R8", "released", bus_hold_o, 0);
  endtask

  task automatic t_split_close();
    send(32'h5000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    beat("R9", 32'h5000, 4, 1'b0, 1'b1);
    send(32'h5006, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9", "viol", atom_viol_o, 1);
    chk("R9", "hold first half", bus_hold_o, 1);
    beat("R9", 32'h5006, 2, 1'b1, 1'b0);
    chk("R9", "hold dropped", bus_hold_o, 0);
    beat("R9", 32'h5008, 2, 1'b1, 1'b1);
    chk("R9", "idle", host_ready_o, 1);
  endtask

  task automatic t_abort();
    send(32'h600, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1);  // abort outside a hold
    chk("R10", "idle abort cmd", cmd_valid_o, 1);
    chk("R10", "idle abort hold", bus_hold_o, 0);
    beat("R10", 32'h600, 4, 1'b0, 1'b1);
    send(32'h700, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    beat("R10", 32'h700, 4, 1'b0, 1'b1);
    send(32'h700, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1);  // abort beats request
    chk("R10", "hold dropped", bus_hold_o, 0);
    chk("R10", "no cmd", cmd_valid_o, 0);
    chk("R10", "ready", host_ready_o, 1);
  endtask

  task automatic t_busy();
    send(32'h800, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R12", "not ready", host_ready_o, 0);
    send(32'h900, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    beat("R12", 32'h800, 4, 1'b0, 1'b1);
    chk("R12", "second dropped", cmd_valid_o, 0);
    chk("R12", "no hold", bus_hold_o, 0);
  endtask

  task automatic t_sizes();
    send(32'hA03, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    beat("R11", 32'hA03, 1, 1'b0, 1'b1);
    send(32'hA10, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    beat("R11", 32'hA10, 4, 1'b1, 1'b1);
    send(32'hA22, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    beat("R11", 32'hA22, 2, 1'b0, 1'b1);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_plain();
    t_rmw_basic();
    t_close_any();
    t_ignore();
    t_split_plain();
    t_split_open();
    t_misalign();
    t_split_close();
    t_abort();
    t_busy();
    t_sizes();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule